// File: doc/BRIEF.md
# Stereo Source Router with Loudspeaker Effects

This block takes three stereo sample sources (auxiliary, SCART and main), six signed PCM channels in all, and routes them to three stereo destinations: loudspeaker, SCART and headphone. Each destination has an independent 4-bit selector. A selector picks one channel of a source, which is then copied onto both the left and the right output, or it picks a whole source in stereo. Each destination also has a mute input.

The loudspeaker destination carries a 3-bit effect mode applied after routing. The modes are plain stereo, stereo widened by subtracting a fixed fraction of the opposite channel, and forced mono. The pseudo-stereo mode is treated as forced mono and raises a flag for later processing. All inputs move on one valid strobe. The outputs are registered one cycle after that strobe and hold their values between strobes.

Top module: `audio_xbar_fx`

## Requirements
- R1: While reset is active, and after it until the first valid strobe, all six sample outputs, `valid_o` and `pseudo_o` are 0.
- R2: Single-channel selector codes copy one input onto both output channels: 0xB aux left, 0xA aux right, 0x9 SCART left, 0x5 SCART right, 0x7 main left, 0x6 main right.
- R3: Stereo selector codes drive left to left and right to right: 0xC aux, 0xD SCART, 0x8 main.
- R4: The three selectors are independent, and one input may feed several destinations in the same cycle.
- R5: A selector code not listed in R2 or R3 drives 0 on both channels of that destination.
- R6: A mute input at 1 drives 0 on both channels of its destination, whatever the selector and mode are.
- R7: Loudspeaker mode 3'b001 passes the routed pair through unchanged.
- R8: Loudspeaker mode 3'b111 outputs L - floor(R*133/256) and R - floor(L*133/256). Mode 3'b011 does the same with 77/256.
- R9: Widened results saturate to +32767 and -32768.
- R10: Loudspeaker modes 3'b000 and 3'b010 output floor((L+R)/2) on both channels. `pseudo_o` follows each strobe and is 1 only for mode 3'b010, whether or not the output is muted.
- R11: Any other loudspeaker mode drives 0 on both loudspeaker channels, with `pseudo_o` at 0.
- R12: Outputs update at the clock edge that samples `valid_i` high. `valid_o` is `valid_i` delayed by one cycle. Outputs hold while `valid_i` is low.
- R13: The effect mode has no influence on the SCART and headphone destinations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input samples valid |
| aux_l_i | input | 16 | Aux left sample |
| aux_r_i | input | 16 | Aux right sample |
| scart_l_i | input | 16 | SCART left sample |
| scart_r_i | input | 16 | SCART right sample |
| main_l_i | input | 16 | Main left sample |
| main_r_i | input | 16 | Main right sample |
| spk_sel_i | input | 4 | Loudspeaker selector |
| scart_sel_i | input | 4 | SCART selector |
| hp_sel_i | input | 4 | Headphone selector |
| spk_mute_i | input | 1 | Loudspeaker mute |
| scart_mute_i | input | 1 | SCART mute |
| hp_mute_i | input | 1 | Headphone mute |
| spk_mode_i | input | 3 | Loudspeaker effect mode |
| valid_o | output | 1 | Output samples valid |
| spk_l_o | output | 16 | Loudspeaker left |
| spk_r_o | output | 16 | Loudspeaker right |
| scart_l_o | output | 16 | SCART left |
| scart_r_o | output | 16 | SCART right |
| hp_l_o | output | 16 | Headphone left |
| hp_r_o | output | 16 | Headphone right |
| pseudo_o | output | 1 | Pseudo-stereo requested |

## Verification
The bench builds the block with its default parameters: 16-bit samples, an 8-bit fraction, and widening coefficients 133 and 77. With these values, full-scale inputs push the widened sum past the 16-bit range, so both saturation limits can be reached. Odd mono sums also arise at these values, which tests the rounding toward negative infinity. Random vectors mix listed and unlisted selector codes with all eight mode values. Directed vectors cover the extreme samples and the hold behaviour between strobes.

// File: rtl/axb_pkg.sv
package axb_pkg;
  typedef enum logic [3:0] {
    SEL_AUX_L   = 4'hB,
    SEL_AUX_R   = 4'hA,
    SEL_AUX_ST  = 4'hC,
    SEL_SCT_L   = 4'h9,
    SEL_SCT_R   = 4'h5,
    SEL_SCT_ST  = 4'hD,
    SEL_MAIN_L  = 4'h7,
    SEL_MAIN_R  = 4'h6,
    SEL_MAIN_ST = 4'h8
  } sel_e;

  typedef enum logic [2:0] {
    MODE_MONO    = 3'b000,
    MODE_STEREO  = 3'b001,
    MODE_PSEUDO  = 3'b010,
    MODE_WIDE_LO = 3'b011,
    MODE_WIDE_HI = 3'b111
  } mode_e;

  // index of each channel in the packed source vector
  localparam int unsigned IDX_AUX_L  = 0;
  localparam int unsigned IDX_AUX_R  = 1;
  localparam int unsigned IDX_SCT_L  = 2;
  localparam int unsigned IDX_SCT_R  = 3;
  localparam int unsigned IDX_MAIN_L = 4;
  localparam int unsigned IDX_MAIN_R = 5;
  localparam int unsigned NUM_SRC    = 6;
  localparam int unsigned NUM_DST    = 3;
endpackage

// File: rtl/axb_route.sv
module axb_route
  import axb_pkg::*;
#(
  parameter int unsigned SW = 16
) (
  input  logic [NUM_SRC-1:0][SW-1:0] src_i,
  input  logic [3:0]                 sel_i,
  output logic signed [SW-1:0]       l_o,
  output logic signed [SW-1:0]       r_o
);
  always_comb begin
    l_o = '0;
    r_o = '0;
    case (sel_i)
      SEL_AUX_L:   begin l_o = src_i[IDX_AUX_L];  r_o = src_i[IDX_AUX_L];  end
      SEL_AUX_R:   begin l_o = src_i[IDX_AUX_R];  r_o = src_i[IDX_AUX_R];  end
      SEL_AUX_ST:  begin l_o = src_i[IDX_AUX_L];  r_o = src_i[IDX_AUX_R];  end
      SEL_SCT_L:   begin l_o = src_i[IDX_SCT_L];  r_o = src_i[IDX_SCT_L];  end
      SEL_SCT_R:   begin l_o = src_i[IDX_SCT_R];  r_o = src_i[IDX_SCT_R];  end
      SEL_SCT_ST:  begin l_o = src_i[IDX_SCT_L];  r_o = src_i[IDX_SCT_R];  end
      SEL_MAIN_L:  begin l_o = src_i[IDX_MAIN_L]; r_o = src_i[IDX_MAIN_L]; end
      SEL_MAIN_R:  begin l_o = src_i[IDX_MAIN_R]; r_o = src_i[IDX_MAIN_R]; end
      SEL_MAIN_ST: begin l_o = src_i[IDX_MAIN_L]; r_o = src_i[IDX_MAIN_R]; end
      default: ; // unlisted code: silence
    endcase
  end
endmodule

// File: rtl/axb_spatial_lane.sv
module axb_spatial_lane #(
  parameter int unsigned SW = 16,
  parameter int unsigned FW = 8
) (
  input  logic signed [SW-1:0] self_i,
  input  logic signed [SW-1:0] other_i,
  input  logic [FW:0]          k_i,
  output logic signed [SW-1:0] y_o
);
  localparam int unsigned PW = SW + FW + 1;
  localparam logic signed [PW:0] MAXV = (PW+1)'((64'sd1 <<< (SW-1)) - 1);
  localparam logic signed [PW:0] MINV = -(PW+1)'(64'sd1 <<< (SW-1));

  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] part;
  logic signed [PW:0]   diff;

  assign prod = PW'(other_i) * $signed({1'b0, k_i});
  assign part = prod >>> FW;  // floor
  assign diff = (PW+1)'(self_i) - (PW+1)'(part);

  always_comb begin
    if (diff > MAXV)      y_o = MAXV[SW-1:0];
    else if (diff < MINV) y_o = MINV[SW-1:0];
    else                  y_o = diff[SW-1:0];
  end
endmodule

// File: rtl/axb_effect.sv
module axb_effect
  import axb_pkg::*;
#(
  parameter int unsigned SW      = 16,
  parameter int unsigned FW      = 8,
  parameter int unsigned K_WIDE  = 133,
  parameter int unsigned K_NARROW = 77
) (
  input  logic [2:0]           mode_i,
  input  logic signed [SW-1:0] l_i,
  input  logic signed [SW-1:0] r_i,
  output logic signed [SW-1:0] l_o,
  output logic signed [SW-1:0] r_o,
  output logic                 pseudo_o
);
  logic [FW:0]          k;
  logic signed [SW:0]   sum;
  logic signed [SW-1:0] mono;
  logic signed [SW-1:0] lane_in  [2];
  logic signed [SW-1:0] lane_out [2];

  assign k    = (mode_i == MODE_WIDE_HI) ? (FW+1)'(K_WIDE) : (FW+1)'(K_NARROW);
  assign sum  = (SW+1)'(l_i) + (SW+1)'(r_i);
  assign mono = SW'(sum >>> 1);
  assign lane_in[0] = l_i;
  assign lane_in[1] = r_i;

  for (genvar g = 0; g < 2; g++) begin : g_lane
    axb_spatial_lane #(.SW(SW), .FW(FW)) u_lane (
      .self_i (lane_in[g]),
      .other_i(lane_in[1-g]),
      .k_i    (k),
      .y_o    (lane_out[g])
    );
  end

  always_comb begin
    pseudo_o = 1'b0;
    l_o      = '0;
    r_o      = '0;
    case (mode_i)
      MODE_STEREO: begin l_o = l_i; r_o = r_i; end
      MODE_MONO:   begin l_o = mono; r_o = mono; end
      MODE_PSEUDO: begin l_o = mono; r_o = mono; pseudo_o = 1'b1; end
      MODE_WIDE_LO,
      MODE_WIDE_HI: begin l_o = lane_out[0]; r_o = lane_out[1]; end
      default: ;
    endcase
  end
endmodule

// File: rtl/audio_xbar_fx.sv
module audio_xbar_fx
  import axb_pkg::*;
#(
  parameter int unsigned SW       = 16,
  parameter int unsigned FW       = 8,
  parameter int unsigned K_WIDE   = 133,
  parameter int unsigned K_NARROW = 77
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic signed [SW-1:0] aux_l_i,
  input  logic signed [SW-1:0] aux_r_i,
  input  logic signed [SW-1:0] scart_l_i,
  input  logic signed [SW-1:0] scart_r_i,
  input  logic signed [SW-1:0] main_l_i,
  input  logic signed [SW-1:0] main_r_i,
  input  logic [3:0]           spk_sel_i,
  input  logic [3:0]           scart_sel_i,
  input  logic [3:0]           hp_sel_i,
  input  logic                 spk_mute_i,
  input  logic                 scart_mute_i,
  input  logic                 hp_mute_i,
  input  logic [2:0]           spk_mode_i,
  output logic                 valid_o,
  output logic signed [SW-1:0] spk_l_o,
  output logic signed [SW-1:0] spk_r_o,
  output logic signed [SW-1:0] scart_l_o,
  output logic signed [SW-1:0] scart_r_o,
  output logic signed [SW-1:0] hp_l_o,
  output logic signed [SW-1:0] hp_r_o,
  output logic                 pseudo_o
);
  localparam int unsigned D_SPK = 0;
  localparam int unsigned D_SCT = 1;
  localparam int unsigned D_HP  = 2;

  logic [NUM_SRC-1:0][SW-1:0] src;
  logic [3:0]           sel    [NUM_DST];
  logic                 mute   [NUM_DST];
  logic signed [SW-1:0] rt_l   [NUM_DST];
  logic signed [SW-1:0] rt_r   [NUM_DST];
  logic signed [SW-1:0] fin_l  [NUM_DST];
  logic signed [SW-1:0] fin_r  [NUM_DST];
  logic signed [SW-1:0] q_l    [NUM_DST];
  logic signed [SW-1:0] q_r    [NUM_DST];
  logic                 fx_pseudo;
  logic                 valid_q, pseudo_q;

  assign src[IDX_AUX_L]  = aux_l_i;
  assign src[IDX_AUX_R]  = aux_r_i;
  assign src[IDX_SCT_L]  = scart_l_i;
  assign src[IDX_SCT_R]  = scart_r_i;
  assign src[IDX_MAIN_L] = main_l_i;
  assign src[IDX_MAIN_R] = main_r_i;

  assign sel[D_SPK]  = spk_sel_i;
  assign sel[D_SCT]  = scart_sel_i;
  assign sel[D_HP]   = hp_sel_i;
  assign mute[D_SPK] = spk_mute_i;
  assign mute[D_SCT] = scart_mute_i;
  assign mute[D_HP]  = hp_mute_i;

  for (genvar d = 0; d < NUM_DST; d++) begin : g_dst
    axb_route #(.SW(SW)) u_route (
      .src_i(src),
      .sel_i(sel[d]),
      .l_o  (rt_l[d]),
      .r_o  (rt_r[d])
    );

    if (d == D_SPK) begin : g_fx
      axb_effect #(.SW(SW), .FW(FW), .K_WIDE(K_WIDE), .K_NARROW(K_NARROW)) u_fx (
        .mode_i  (spk_mode_i),
        .l_i     (rt_l[d]),
        .r_i     (rt_r[d]),
        .l_o     (fin_l[d]),
        .r_o     (fin_r[d]),
        .pseudo_o(fx_pseudo)
      );
    end else begin : g_pass
      assign fin_l[d] = rt_l[d];
      assign fin_r[d] = rt_r[d];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q_l[d] <= '0;
        q_r[d] <= '0;
      end else if (valid_i) begin
        q_l[d] <= mute[d] ? '0 : fin_l[d];
        q_r[d] <= mute[d] ? '0 : fin_r[d];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= 1'b0;
      pseudo_q <= 1'b0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) pseudo_q <= fx_pseudo;
    end
  end

  assign valid_o   = valid_q;
  assign pseudo_o  = pseudo_q;
  assign spk_l_o   = q_l[D_SPK];
  assign spk_r_o   = q_r[D_SPK];
  assign scart_l_o = q_l[D_SCT];
  assign scart_r_o = q_r[D_SCT];
  assign hp_l_o    = q_l[D_HP];
  assign hp_r_o    = q_r[D_HP];
endmodule

// File: rtl/axb_checker.sv
module axb_checker #(
  parameter int unsigned SW = 16
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 valid_i,
  input logic signed [SW-1:0] main_l_i,
  input logic signed [SW-1:0] main_r_i,
  input logic [3:0]           scart_sel_i,
  input logic                 spk_mute_i,
  input logic                 scart_mute_i,
  input logic [2:0]           spk_mode_i,
  input logic                 valid_o,
  input logic signed [SW-1:0] spk_l_o,
  input logic signed [SW-1:0] spk_r_o,
  input logic signed [SW-1:0] scart_l_o,
  input logic signed [SW-1:0] scart_r_o,
  input logic                 pseudo_o
);
  assert_valid_delay_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_valid_low_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  assert_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(spk_l_o) && $stable(spk_r_o) && $stable(scart_l_o)));
  assert_spk_mute_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && spk_mute_i) |=> (spk_l_o == '0 && spk_r_o == '0));
  assert_mono_equal_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (spk_mode_i == 3'b000 || spk_mode_i == 3'b010)) |=> (spk_l_o == spk_r_o));
  assert_pseudo_flag_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && spk_mode_i == 3'b010) |=> pseudo_o);
  assert_stereo_main_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !scart_mute_i && scart_sel_i == 4'h8)
      |=> (scart_l_o == $past(main_l_i) && scart_r_o == $past(main_r_i)));
endmodule

bind audio_xbar_fx axb_checker #(.SW(SW)) u_chk (.*);

// File: tb/audio_xbar_fx_tb.sv
`timescale 1ns/1ps
module audio_xbar_fx_tb;
  logic clk = 1'b0, rst_n = 1'b0, valid = 1'b0;
  logic signed [15:0] src [6];
  logic [3:0] sel [3];
  logic mute [3];
  logic [2:0] mode = 3'b001;
  logic valid_o, pseudo_o;
  logic signed [15:0] spk_l, spk_r, sct_l, sct_r, hp_l, hp_r;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  audio_xbar_fx u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid),
    .aux_l_i(src[0]), .aux_r_i(src[1]), .scart_l_i(src[2]), .scart_r_i(src[3]),
    .main_l_i(src[4]), .main_r_i(src[5]),
    .spk_sel_i(sel[0]), .scart_sel_i(sel[1]), .hp_sel_i(sel[2]),
    .spk_mute_i(mute[0]), .scart_mute_i(mute[1]), .hp_mute_i(mute[2]),
    .spk_mode_i(mode), .valid_o(valid_o),
    .spk_l_o(spk_l), .spk_r_o(spk_r), .scart_l_o(sct_l), .scart_r_o(sct_r),
    .hp_l_o(hp_l), .hp_r_o(hp_r), .pseudo_o(pseudo_o));

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic void route(input logic [3:0] s, output int l, output int r);
    l = 0; r = 0;
    case (s)
      4'hB: begin l = src[0]; r = src[0]; end
      4'hA: begin l = src[1]; r = src[1]; end
      4'hC: begin l = src[0]; r = src[1]; end
      4'h9: begin l = src[2]; r = src[2]; end
      4'h5: begin l = src[3]; r = src[3]; end
      4'hD: begin l = src[2]; r = src[3]; end
      4'h7: begin l = src[4]; r = src[4]; end
      4'h6: begin l = src[5]; r = src[5]; end
      4'h8: begin l = src[4]; r = src[5]; end
      default: ;
    endcase
  endfunction

  function automatic int sat(int v);
    return v > 32767 ? 32767 : (v < -32768 ? -32768 : v);
  endfunction

  function automatic int wide(int a, int b, int k);
    int p = b * k;
    return sat(a - (p >>> 8));
  endfunction

  function automatic void fx(input int l, input int r, output int ol, output int orr, output int ps);
    int m = (l + r) >>> 1;
    ps = 0; ol = 0; orr = 0;
    case (mode)
      3'b001: begin ol = l; orr = r; end
      3'b000: begin ol = m; orr = m; end
      3'b010: begin ol = m; orr = m; ps = 1; end
      3'b111: begin ol = wide(l, r, 133); orr = wide(r, l, 133); end
      3'b011: begin ol = wide(l, r, 77); orr = wide(r, l, 77); end
      default: ;
    endcase
  endfunction

  // apply one strobe, then compare every output against the model
  task automatic step(string req);
    int el[3], er[3], ps, tl, tr;
    for (int d = 0; d < 3; d++) route(sel[d], el[d], er[d]);
    fx(el[0], er[0], tl, tr, ps);
    el[0] = tl; er[0] = tr;
    for (int d = 0; d < 3; d++) if (mute[d]) begin el[d] = 0; er[d] = 0; end
    valid = 1'b1;
    @(posedge clk); @(negedge clk);
    valid = 1'b0;
    chk(req, "valid_o", int'(valid_o), 1);
    chk(req, "pseudo", int'(pseudo_o), ps);
    chk(req, "spk_l", spk_l, el[0]); chk(req, "spk_r", spk_r, er[0]);
    chk(req, "sct_l", sct_l, el[1]); chk(req, "sct_r", sct_r, er[1]);
    chk(req, "hp_l", hp_l, el[2]);   chk(req, "hp_r", hp_r, er[2]);
  endtask

  task automatic set_src(int a0, int a1, int a2, int a3, int a4, int a5);
    src[0] = 16'(a0); src[1] = 16'(a1); src[2] = 16'(a2);
    src[3] = 16'(a3); src[4] = 16'(a4); src[5] = 16'(a5);
  endtask

  task automatic set_dst(logic [3:0] s0, logic [3:0] s1, logic [3:0] s2, logic [2:0] m);
    sel[0] = s0; sel[1] = s1; sel[2] = s2; mode = m;
  endtask

  initial begin
    #4000000;
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [3:0] codes [9] = '{4'hB, 4'hA, 4'hC, 4'h9, 4'h5, 4'hD, 4'h7, 4'h6, 4'h8};
    int hold_l;
    void'($urandom(32'd1234));
    set_src(100, -200, 300, -400, 500, -600);
    set_dst(4'h8, 4'h8, 4'h8, 3'b001);
    for (int d = 0; d < 3; d++) mute[d] = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "spk_l in reset", spk_l, 0);
    chk("R1", "valid_o in reset", int'(valid_o), 0);
    rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R1", "hp_r after reset", hp_r, 0);
    chk("R1", "pseudo after reset", int'(pseudo_o), 0);

    set_src(11, -22, 33, -44, 55, -66);
    set_dst(4'hB, 4'h5, 4'h6, 3'b001); step("R2");
    set_dst(4'hA, 4'h9, 4'h7, 3'b001); step("R2");
    set_dst(4'hC, 4'hD, 4'h8, 3'b001); step("R3");
    set_dst(4'h8, 4'h8, 4'h8, 3'b001); step("R4");
    set_dst(4'h0, 4'hF, 4'h3, 3'b001); step("R5");
    set_dst(4'hE, 4'h1, 4'h4, 3'b001); step("R5");
    mute[0] = 1; mute[1] = 1; mute[2] = 1;
    set_dst(4'hC, 4'hD, 4'h8, 3'b111); step("R6");
    mute[0] = 0; mute[1] = 0; mute[2] = 0;
    set_dst(4'hC, 4'hC, 4'hC, 3'b001); step("R7");
    set_src(1000, -3000, 0, 0, 0, 0);
    set_dst(4'hC, 4'hC, 4'hC, 3'b111); step("R8");
    chk("R8", "wide hi left", spk_l, 1000 + 1559);
    set_dst(4'hC, 4'hC, 4'hC, 3'b011); step("R8");
    set_src(32767, -32768, 0, 0, 0, 0);
    set_dst(4'hC, 4'hD, 4'hC, 3'b111); step("R9");
    chk("R9", "sat high", spk_l, 32767);
    chk("R9", "sat low", spk_r, -32768);
    set_src(3, -6, 0, 0, 0, 0);
    set_dst(4'hC, 4'hC, 4'hC, 3'b000); step("R10");
    chk("R10", "mono floor", spk_l, -2);
    set_dst(4'hC, 4'hC, 4'hC, 3'b010); step("R10");
    mute[0] = 1; step("R10"); mute[0] = 0;
    set_dst(4'hC, 4'hC, 4'hC, 3'b100); step("R11");
    set_dst(4'hC, 4'hC, 4'hC, 3'b110); step("R11");
    set_src(7, 9, 0, 0, 0, 0);
    set_dst(4'hC, 4'hC, 4'hC, 3'b000); step("R13");
    chk("R13", "scart untouched by mode", sct_r, 9);

    // hold while valid low
    hold_l = spk_l;
    set_src(-1, -1, -1, -1, -1, -1);
    repeat (3) @(negedge clk);
    chk("R12", "hold spk_l", spk_l, hold_l);
    chk("R12", "valid_o low", int'(valid_o), 0);

    for (int i = 0; i < 400; i++) begin
      for (int j = 0; j < 6; j++) src[j] = 16'($urandom);
      if (i % 8 == 0) begin src[0] = 16'sh7fff; src[1] = 16'sh8000; end
      for (int d = 0; d < 3; d++) begin
        sel[d]  = ($urandom_range(0, 5) == 0) ? 4'($urandom) : codes[$urandom_range(0, 8)];
        mute[d] = ($urandom_range(0, 9) == 0);
      end
      mode = 3'($urandom);
      step("R2 random");
      if ($urandom_range(0, 3) == 0) @(negedge clk);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule